// File: doc/BRIEF.md
# RF Front-End Switch Sequencer

This block drives the control lines of an external radio front end: one enable line for the transmit power amplifier, one for the receive low-noise amplifier, and two complementary lines that choose between two antennas. A one-cycle request pulse switches the amplifier pair into receive or transmit mode. The two amplifier lines never change together. The first line moves on the edge that accepts the request. The second line moves after a long settling gap. The sequence is then held for a short gap before `busy` drops.

Both gaps are given in microseconds and turned into whole clock cycles from the clock-frequency parameter, always rounding up. Antenna selection is a plain registered input and does not depend on the amplifier sequence. Out of reset the block selects antenna 0 and runs the receive sequence once by itself.

Top module: `rf_switch_seq`

## Requirements
- R1: A receive request drives `lna_rx_en` to 1 on the accepting clock edge, drives `pa_tx_en` to 0 exactly N_LONG cycles later, and releases `busy` N_SHORT cycles after that.
- R2: A transmit request drives `lna_rx_en` to 0 on the accepting clock edge, drives `pa_tx_en` to 1 exactly N_LONG cycles later, and releases `busy` N_SHORT cycles after that.
- R3: `pa_tx_en` and `lna_rx_en` never change on the same clock edge.
- R4: N_LONG = ceil(CLK_HZ x FIRST_GAP_US / 1e6) and N_SHORT = ceil(CLK_HZ x SECOND_GAP_US / 1e6), with a minimum of 1. For example, at 1.5 MHz with 20 us and 5 us the values are 30 and 8.
- R5: `busy` rises on the accepting edge, stays high for exactly N_LONG + N_SHORT cycles, and is low when the block is idle.
- R6: A request of either kind that arrives while `busy` is high is ignored. The running sequence neither restarts nor changes direction.
- R7: A request for the mode already in force still runs the full timed sequence, and the amplifier lines keep their levels.
- R8: With `ant_sel` = 0, `ant_tx_side` = 1 and `ant_rx_side` = 0. With `ant_sel` = 1, `ant_tx_side` = 0 and `ant_rx_side` = 1.
- R9: `ant_sel` is registered. The antenna lines follow it one clock edge later, including while a sequence is running.
- R10: While reset is active, `pa_tx_en` = 0, `lna_rx_en` = 0, antenna 0 is selected and `busy` = 1. The first edge after reset release starts a receive sequence as in R1.
- R11: If `req_rx` and `req_tx` are both high in an idle cycle, the receive request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rx | input | 1 | Request to enter receive mode |
| req_tx | input | 1 | Request to enter transmit mode |
| ant_sel | input | 1 | Antenna choice, 0 or 1 |
| pa_tx_en | output | 1 | Power amplifier enable (transmit side) |
| lna_rx_en | output | 1 | Low-noise amplifier enable (receive side) |
| ant_tx_side | output | 1 | Antenna switch line, high for antenna 0 |
| ant_rx_side | output | 1 | Antenna switch line, high for antenna 1 |
| busy | output | 1 | Sequence in progress |

## Verification
Several properties are checked on every cycle:
- the two amplifier lines never move together;
- the antenna pair stays complementary and follows the registered select;
- once a sequence starts, `busy` holds until it ends;
- a counter in the checker confirms the length of the first gap and the total busy window.

Some behaviours can only be shown by the bench's scenarios:
- which line moves first and to what level, for each direction;
- that a mid-sequence request leaves the final levels untouched;
- that a same-mode request still costs a full window;
- that receive wins a simultaneous request;
- that the self-started receive sequence after reset happens.

// File: rtl/rfsw_pkg.sv
package rfsw_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BOOT = 2'd1,
    SQ_GAP1 = 2'd2,
    SQ_GAP2 = 2'd3
  } sq_state_t;

  // Whole cycles covering a gap in microseconds, rounded up, never below 1.
  function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
    logic [63:0] prod;
    logic [63:0] cyc;
    prod = 64'(clk_hz) * 64'(us);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc[31:0];
  endfunction

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned top;
    top = (a > b) ? a : b;
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/rfsw_gap_timer.sv
module rfsw_gap_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rfsw_seq_fsm.sv
module rfsw_seq_fsm
  import rfsw_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned N_LONG  = 20,
  parameter int unsigned N_SHORT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rx,
  input  logic             req_tx,
  input  logic             expire,
  output logic             pa_tx_en,
  output logic             lna_rx_en,
  output logic             busy,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             run,
  output logic             seq_start,
  output logic             gap1_done,
  output logic             seq_done
);
  sq_state_t state_q;
  logic      tgt_tx_q;
  logic      go_tx;

  always_comb begin
    seq_start = (state_q == SQ_BOOT) ||
                ((state_q == SQ_IDLE) && (req_rx || req_tx));
    // receive has priority when both requests arrive together
    go_tx     = (state_q == SQ_IDLE) && !req_rx && req_tx;
    gap1_done = (state_q == SQ_GAP1) && expire;
    seq_done  = (state_q == SQ_GAP2) && expire;
    run       = (state_q == SQ_GAP1) || (state_q == SQ_GAP2);
    load      = seq_start || gap1_done;
    load_val  = seq_start ? CNT_W'(N_LONG) : CNT_W'(N_SHORT);
    busy      = (state_q != SQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_BOOT;
      tgt_tx_q  <= 1'b0;
      pa_tx_en  <= 1'b0;
      lna_rx_en <= 1'b0;
    end else if (seq_start) begin
      tgt_tx_q  <= go_tx;
      lna_rx_en <= ~go_tx;
      state_q   <= SQ_GAP1;
    end else if (gap1_done) begin
      pa_tx_en  <= tgt_tx_q;
      state_q   <= SQ_GAP2;
    end else if (seq_done) begin
      state_q   <= SQ_IDLE;
    end
  end
endmodule

// File: rtl/rfsw_ant_sel.sv
module rfsw_ant_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic ant_sel,
  output logic ant_tx_side,
  output logic ant_rx_side
);
  logic ant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ant_q <= 1'b0;
    else        ant_q <= ant_sel;
  end

  assign ant_tx_side = ~ant_q;
  assign ant_rx_side = ant_q;
endmodule

// File: rtl/rf_switch_seq.sv
module rf_switch_seq
  import rfsw_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned FIRST_GAP_US  = 20,
  parameter int unsigned SECOND_GAP_US = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_rx,
  input  logic req_tx,
  input  logic ant_sel,
  output logic pa_tx_en,
  output logic lna_rx_en,
  output logic ant_tx_side,
  output logic ant_rx_side,
  output logic busy
);
  localparam int unsigned N_LONG  = us_to_cycles(CLK_HZ, FIRST_GAP_US);
  localparam int unsigned N_SHORT = us_to_cycles(CLK_HZ, SECOND_GAP_US);
  localparam int unsigned CNT_W   = cnt_width(N_LONG, N_SHORT);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             run;
  logic             expire;
  logic             seq_start;
  logic             gap1_done;
  logic             seq_done;

  rfsw_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .run(run), .expire(expire)
  );

  rfsw_seq_fsm #(.CNT_W(CNT_W), .N_LONG(N_LONG), .N_SHORT(N_SHORT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_rx(req_rx), .req_tx(req_tx),
    .expire(expire), .pa_tx_en(pa_tx_en), .lna_rx_en(lna_rx_en),
    .busy(busy), .load(load), .load_val(load_val), .run(run),
    .seq_start(seq_start), .gap1_done(gap1_done), .seq_done(seq_done)
  );

  rfsw_ant_sel u_ant (
    .clk(clk), .rst_n(rst_n), .ant_sel(ant_sel),
    .ant_tx_side(ant_tx_side), .ant_rx_side(ant_rx_side)
  );
endmodule

// File: rtl/rfsw_seq_chk.sv
module rfsw_seq_chk
  import rfsw_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned FIRST_GAP_US  = 20,
  parameter int unsigned SECOND_GAP_US = 5
) (
  input logic clk,
  input logic rst_n,
  input logic ant_sel,
  input logic pa_tx_en,
  input logic lna_rx_en,
  input logic ant_tx_side,
  input logic ant_rx_side,
  input logic busy,
  input logic seq_start,
  input logic gap1_done,
  input logic seq_done
);
  localparam int unsigned C_LONG  = us_to_cycles(CLK_HZ, FIRST_GAP_US);
  localparam int unsigned C_SHORT = us_to_cycles(CLK_HZ, SECOND_GAP_US);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_run <= 0;
    else if (seq_start) busy_run <= 0;
    else if (busy)      busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  assert_amp_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((pa_tx_en != $past(pa_tx_en)) && (lna_rx_en != $past(lna_rx_en))));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == C_LONG + C_SHORT));

  assert_gap1_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gap1_done |-> (busy_run == C_LONG - 1));

  assert_ant_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ant_tx_side != ant_rx_side);

  assert_ant_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ant_rx_side == $past(ant_sel)));
endmodule

bind rf_switch_seq rfsw_seq_chk #(
  .CLK_HZ(CLK_HZ), .FIRST_GAP_US(FIRST_GAP_US), .SECOND_GAP_US(SECOND_GAP_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ant_sel(ant_sel), .pa_tx_en(pa_tx_en),
  .lna_rx_en(lna_rx_en), .ant_tx_side(ant_tx_side), .ant_rx_side(ant_rx_side),
  .busy(busy), .seq_start(seq_start), .gap1_done(gap1_done), .seq_done(seq_done)
);

// File: tb/sim_rf_switch_seq.sv
module sim_rf_switch_seq;
  // 1.5 MHz: 20 us -> 30 cycles, 5 us -> 7.5 -> rounded up to 8 cycles (R4)
  localparam int unsigned TB_CLK_HZ = 1_500_000;
  localparam int NL = 30;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_rx = 1'b0, req_tx = 1'b0, ant_sel = 1'b0;
  logic pa_tx_en, lna_rx_en, ant_tx_side, ant_rx_side, busy;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_pa = 1'b0;

  always #5 clk = ~clk;

  rf_switch_seq #(.CLK_HZ(TB_CLK_HZ), .FIRST_GAP_US(20), .SECOND_GAP_US(5)) u0 (
    .clk(clk), .rst_n(rst_n), .req_rx(req_rx), .req_tx(req_tx), .ant_sel(ant_sel),
    .pa_tx_en(pa_tx_en), .lna_rx_en(lna_rx_en), .ant_tx_side(ant_tx_side),
    .ant_rx_side(ant_rx_side), .busy(busy)
  );

  typedef struct packed {
    logic want_tx;
    logic ant;
    logic e_pa;
    logic e_lna;
    logic e_ant_tx;
    logic e_ant_rx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Pulse requests for one cycle; returns at the negedge after the accepting edge.
  task automatic pulse_req(logic rx, logic tx);
    req_rx = rx; req_tx = tx;
    @(negedge clk);
    req_rx = 1'b0; req_tx = 1'b0;
  endtask

  task automatic run_seq(logic rx, logic tx, string tag);
    logic to_tx;
    logic old_pa;
    to_tx  = !rx && tx;
    old_pa = exp_pa;
    pulse_req(rx, tx);
    check({tag, " first line"}, lna_rx_en, !to_tx);
    check({tag, " busy rise R5"}, busy, 1'b1);
    repeat (NL - 1) @(negedge clk);
    check({tag, " second line held R3"}, pa_tx_en, old_pa);
    @(negedge clk);
    check({tag, " second line moved"}, pa_tx_en, to_tx);
    repeat (NS - 1) @(negedge clk);
    check({tag, " busy before end R4"}, busy, 1'b1);
    @(negedge clk);
    check({tag, " busy end R5"}, busy, 1'b0);
    exp_pa = to_tx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 pa in reset", pa_tx_en, 1'b0);
    check("R10 lna in reset", lna_rx_en, 1'b0);
    check("R10 ant tx side in reset", ant_tx_side, 1'b1);
    check("R10 ant rx side in reset", ant_rx_side, 1'b0);
    check("R10 busy in reset", busy, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 boot rx first line", lna_rx_en, 1'b1);
    repeat (NL + NS - 1) @(negedge clk);
    check("R10 boot busy held", busy, 1'b1);
    check("R10 boot pa low", pa_tx_en, 1'b0);
    @(negedge clk);
    check("R10 boot busy end", busy, 1'b0);
    exp_pa = 1'b0;

    // Table walk: R1 R2 R7 R8
    for (int i = 0; i < 6; i++) begin
      ant_sel = VECS[i].ant;
      run_seq(!VECS[i].want_tx, VECS[i].want_tx,
              VECS[i].want_tx ? "R2 tx" : "R1 rx");
      check("R7 final pa", pa_tx_en, VECS[i].e_pa);
      check("R7 final lna", lna_rx_en, VECS[i].e_lna);
      check("R8 ant tx side", ant_tx_side, VECS[i].e_ant_tx);
      check("R8 ant rx side", ant_rx_side, VECS[i].e_ant_rx);
      repeat (2) @(negedge clk);
    end

    // R6 + R9: rx request and antenna change while a tx sequence runs
    ant_sel = 1'b0;
    @(negedge clk);
    pulse_req(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    ant_sel = 1'b1;
    @(negedge clk);
    check("R9 ant follows while busy", ant_rx_side, 1'b1);
    check("R9 ant pair while busy", ant_tx_side, 1'b0);
    req_rx = 1'b1;
    @(negedge clk);
    req_rx = 1'b0;
    check("R6 lna unchanged by ignored rx", lna_rx_en, 1'b0);
    repeat (NL - 7) @(negedge clk);
    check("R6 pa held before gap end", pa_tx_en, 1'b0);
    @(negedge clk);
    check("R6 pa rises on schedule", pa_tx_en, 1'b1);
    repeat (NS) @(negedge clk);
    check("R6 busy ends on schedule", busy, 1'b0);
    repeat (5) @(negedge clk);
    check("R6 no rerun busy", busy, 1'b0);
    check("R6 lna stays low", lna_rx_en, 1'b0);
    check("R6 pa stays high", pa_tx_en, 1'b1);
    exp_pa = 1'b1;

    // R11: simultaneous requests, receive wins
    run_seq(1'b1, 1'b1, "R11 both");
    check("R11 lna high", lna_rx_en, 1'b1);
    check("R11 pa low", pa_tx_en, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule